// File: doc/BRIEF.md
# Block Write-Protect Guard

This block owns the write-protect control register of a byte-addressed nonvolatile array. The register sits at the highest address of the array space. For every write request the surrounding controller presents the target address. The block answers with a combinational grant that says whether the self-timed write may start. The controller samples that grant once, when the write begins.

The register carries three controls. The first is a software write-enable latch, which must be set before any array byte can change. The second is a two-bit size field that protects none, the top quarter, the top half or all of the array. The third is a lock-enable bit. When the lock-enable bit is set and the hardware protect pin is high, the register freezes. This lets a board program the array in place with the pin high and then lock it by setting the lock-enable bit. Pulling the pin low unfreezes the register. Block protection of the array stays in force either way.

Top module: `wp_guard`

## Requirements
- R1: After reset the register reads 8'h00, so every array write is refused.
- R2: A write to any array address other than the register address is granted only when the write-enable latch (bit 1) is 1.
- R3: The size field (bits 4:3) protects array addresses whose two top address bits match: 0 protects nothing, 1 protects top bits 2'b11, 2 protects top bits 2'b1x, and 3 protects every address. A write to a protected address is never granted.
- R4: The register lives at the all-ones address. A register write stores bit 7, bits 4:3 and bit 1 of the data byte. Bits 6:5, 2 and 0 always read 0.
- R5: When bit 7 (lock enable) is 1 and the protect pin is high, the grant for the register address is 0 and register writes leave the register unchanged.
- R6: When the protect pin is high and bit 7 is 0, register writes are granted and take effect, whatever the write-enable latch holds.
- R7: When the protect pin is low, register writes are granted even if bit 7 is 1, while R2 and R3 still govern array addresses.
- R8: A register write strobe with any address other than the all-ones address leaves the register unchanged.
- R9: The grant output follows the address, the register and the pin in the same cycle. A register write becomes visible on the register output one clock edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Address of the current write request |
| reg_wr_i | input | 1 | Write strobe, acts only at the register address |
| wdata_i | input | 8 | Data byte for a register write |
| wp_pin_i | input | 1 | Hardware protect pin, high means protect |
| wr_grant_o | output | 1 | Write allowed for addr_i, combinational |
| reg_o | output | 8 | Current register contents |

## Verification
The bench builds the block with ADDR_W = 13, which gives an 8192-byte space. At that width the quarter boundary (17FFh/1800h), the half boundary (0FFFh/1000h) and the register address 1FFFh can all be driven directly. Random addresses are biased toward those edges and toward the register address. The pin toggles freely, so the bench reaches locked, in-place-programming and unlocked combinations under every size setting.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
  typedef struct packed {
    logic       lock_en;
    logic [1:0] rsv_hi;
    logic [1:0] blk_sz;
    logic       rsv_mid;
    logic       wr_en;
    logic       rsv_lo;
  } wp_reg_t;

  localparam logic [7:0] WP_MASK = 8'h9A;

  typedef enum logic [1:0] {
    BLK_NONE    = 2'd0,
    BLK_QUARTER = 2'd1,
    BLK_HALF    = 2'd2,
    BLK_ALL     = 2'd3
  } blk_sz_e;
endpackage

// File: rtl/wp_range_decode.sv
module wp_range_decode #(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        blk_sz_i,
  output logic              hit_o
);
  import wp_guard_pkg::*;

  logic [1:0] top_bits;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_bits = addr_i[ADDR_W-1 -: 2];
    end else begin : g_narrow
      assign top_bits = {addr_i[0], addr_i[0]};
    end
  endgenerate

  always_comb begin
    unique case (blk_sz_e'(blk_sz_i))
      BLK_NONE:    hit_o = 1'b0;
      BLK_QUARTER: hit_o = (top_bits == 2'b11);
      BLK_HALF:    hit_o = top_bits[1];
      BLK_ALL:     hit_o = 1'b1;
      default:     hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_reg.sv
module wp_reg (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [7:0]            data_i,
  output wp_guard_pkg::wp_reg_t q_o
);
  import wp_guard_pkg::*;

  wp_reg_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (load_i) q <= wp_reg_t'(data_i & WP_MASK);
  end

  assign q_o = q;
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wp_pin_i,
  output logic              wr_grant_o,
  output logic [7:0]        reg_o
);
  import wp_guard_pkg::*;

  localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};

  wp_reg_t cur;
  logic    is_reg, blk_hit, reg_open, arr_open, load;

  wp_range_decode #(.ADDR_W(ADDR_W)) u_range (
    .addr_i   (addr_i),
    .blk_sz_i (cur.blk_sz),
    .hit_o    (blk_hit)
  );

  assign is_reg   = (addr_i == REG_ADDR);
  // register locked only while both lock bit and pin are asserted
  assign reg_open = ~(cur.lock_en & wp_pin_i);
  assign arr_open = cur.wr_en & ~blk_hit;
  assign wr_grant_o = is_reg ? reg_open : arr_open;
  assign load     = reg_wr_i & is_reg & reg_open;

  wp_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (wdata_i),
    .q_o    (cur)
  );

  assign reg_o = cur;
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              reg_wr_i,
  input logic [7:0]        wdata_i,
  input logic              wp_pin_i,
  input logic              wr_grant_o,
  input logic [7:0]        reg_o
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  // R4
  a_r4_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_o & 8'h65) == 8'h00);

  // R2
  a_r2_need_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != TOP && !reg_o[1]) |-> !wr_grant_o);

  // R3
  a_r3_all_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != TOP && reg_o[4:3] == 2'b11) |-> !wr_grant_o);

  // R5
  a_r5_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && addr_i == TOP && reg_o[7] && wp_pin_i) |=> $stable(reg_o));

  // R8
  a_r8_other_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && addr_i != TOP) |=> $stable(reg_o));

  // R6, R7
  a_r6_open_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && addr_i == TOP && !(reg_o[7] && wp_pin_i))
      |=> reg_o == ($past(wdata_i) & 8'h9A));
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .reg_wr_i   (reg_wr_i),
  .wdata_i    (wdata_i),
  .wp_pin_i   (wp_pin_i),
  .wr_grant_o (wr_grant_o),
  .reg_o      (reg_o)
);

// File: tb/wp_guard_test.sv
`timescale 1ns/1ps
module wp_guard_test;
  localparam int ADDR_W = 13;
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              reg_wr_i = 1'b0;
  logic [7:0]        wdata_i = '0;
  logic              wp_pin_i = 1'b0;
  logic              wr_grant_o;
  logic [7:0]        reg_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h00;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  wp_guard #(.ADDR_W(ADDR_W)) uut (.*);

  function automatic logic prot(logic [ADDR_W-1:0] a, logic [1:0] sz);
    case (sz)
      2'd0: return 1'b0;
      2'd1: return a[ADDR_W-1:ADDR_W-2] == 2'b11;
      2'd2: return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic exp_grant(logic [ADDR_W-1:0] a, logic [7:0] r, logic wp);
    if (a == TOP) return !(r[7] && wp);
    return r[1] && !prot(a, r[4:3]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, check grant, clock, check register
  task automatic step(logic [ADDR_W-1:0] a, logic wr, logic [7:0] d, logic wp, string req);
    @(negedge clk_i);
    addr_i = a; reg_wr_i = wr; wdata_i = d; wp_pin_i = wp;
    #1;
    chk({req, " grant"}, wr_grant_o, exp_grant(a, model, wp));
    if (wr && a == TOP && !(model[7] && wp)) model = d & 8'h9A;
    @(posedge clk_i);
    #1;
    reg_wr_i = 1'b0;
    chk({req, " reg"}, reg_o, model);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    // R1 reset state
    chk("R1 reg", reg_o, 8'h00);
    addr_i = 13'h0100; #1;
    chk("R1 grant", wr_grant_o, 1'b0);
    rst_ni = 1'b1;
    step(13'h0100, 1'b0, 8'h00, 1'b0, "R1");
    // R4 mask, R6 writable with pin high and no lock, no WEL needed
    step(TOP, 1'b1, 8'hFF & 8'h7F, 1'b1, "R6");
    chk("R4 mask", reg_o, 8'h1A);
    step(TOP, 1'b1, 8'h02, 1'b1, "R4");
    step(13'h1FFE, 1'b0, 8'h00, 1'b0, "R2 wel on");
    step(13'h0000, 1'b0, 8'h00, 1'b0, "R2 wel on");
    // R8 strobe at non-register address
    step(13'h1FFE, 1'b1, 8'h98, 1'b0, "R8");
    chk("R8 unchanged", reg_o, 8'h02);
    // R3 quarter boundary
    step(TOP, 1'b1, 8'h0A, 1'b0, "R3 set q");
    step(13'h17FF, 1'b0, 8'h00, 1'b0, "R3 q below");
    step(13'h1800, 1'b0, 8'h00, 1'b0, "R3 q at");
    // R3 half boundary
    step(TOP, 1'b1, 8'h12, 1'b0, "R3 set h");
    step(13'h0FFF, 1'b0, 8'h00, 1'b0, "R3 h below");
    step(13'h1000, 1'b0, 8'h00, 1'b0, "R3 h at");
    step(TOP, 1'b1, 8'h1A, 1'b0, "R3 set all");
    step(13'h0000, 1'b0, 8'h00, 1'b0, "R3 all");
    // R5 lock with pin high
    step(TOP, 1'b1, 8'h8A, 1'b1, "R5 set lock");
    step(TOP, 1'b1, 8'h00, 1'b1, "R5 locked");
    chk("R5 held", reg_o, 8'h8A);
    step(13'h1900, 1'b0, 8'h00, 1'b1, "R5 array quarter");
    // R7 pin low unlocks register, blocks still apply
    step(13'h1900, 1'b0, 8'h00, 1'b0, "R7 array");
    step(13'h0200, 1'b0, 8'h00, 1'b0, "R7 array low");
    step(TOP, 1'b1, 8'h82, 1'b0, "R7 unlock");
    chk("R7 written", reg_o, 8'h82);
    // R9 grant tracks pin in same cycle
    @(negedge clk_i); addr_i = TOP; wp_pin_i = 1'b1; #1;
    chk("R9 comb", wr_grant_o, 1'b0);
    wp_pin_i = 1'b0; #1;
    chk("R9 comb", wr_grant_o, 1'b1);
    // random mix
    void'($urandom(32'h5EED));
    for (int i = 0; i < 600; i++) begin
      logic [ADDR_W-1:0] a;
      int sel = $urandom_range(0, 3);
      case (sel)
        0: a = TOP;
        1: a = {2'b11, {(ADDR_W-2){1'b0}}} - ADDR_W'($urandom_range(0, 1));
        2: a = {2'b10, {(ADDR_W-2){1'b0}}} - ADDR_W'($urandom_range(0, 1));
        default: a = ADDR_W'($urandom);
      endcase
      step(a, 1'($urandom), 8'($urandom), 1'($urandom), "R2 R3 R5 R7 rand");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule